// File: doc/BRIEF.md
# Decimal Stored-Program Accumulator Core

This block is a small stored-program processor built around a single accumulator. Every memory word carries a decimal value between 0 and 9999. The hundreds-and-above part of the value selects the operation and the remainder after division by 100 selects an operand location. Program and data share one untagged word memory. A word is treated as an instruction when the program counter reaches it, and as a number when an operand field points at it.

While reset is held, the surrounding logic fills the memory through a write-enable loader port. Releasing reset starts the run at location 1. Each instruction passes through fetch, decode and execute phases and takes four clock cycles. A print instruction places a memory word on an output with a single-cycle strobe. The core stops on a halt or on an unusable instruction, and reports that it has stopped on a flag. Division by zero sets a second flag, which stays set until the next reset.

Top module: `dacc_core`

## Requirements
- R1: A word's opcode is its value divided by 100 and its operand location is its value modulo 100. Locations 1 to 15 are valid operands. Operand location 0, or any operand location above 15, halts the core when decoded.
- R2: Opcode 1 adds the operand word to the accumulator, modulo 10000 (9999 + 1 gives 0).
- R3: Opcode 4 subtracts the operand word. A result below zero wraps by adding 10000 (5 − 7 gives 9998).
- R4: Opcode 2 multiplies the accumulator by the operand word and keeps the product modulo 10000.
- R5: Opcode 3 divides the accumulator by the operand word and truncates the quotient. A zero divisor leaves the accumulator unchanged and sets `div_fault`, which stays high until reset.
- R6: Opcode 5 copies the operand word into the accumulator. Opcode 6 writes the accumulator into the operand location and replaces what that location held.
- R7: Opcode 7 drives `print_valid` high for exactly one cycle and puts the operand word on `print_word`.
- R8: After reset the program counter is at location 1, never at location 0. It advances by one per instruction, so instructions take effect in ascending location order.
- R9: Opcode 0 and opcodes 8 to 99 raise `halted`, and so does a program counter that passes location 15. Once raised, `halted` stays high and no further print strobe appears.
- R10: While `rst` is high, loader writes go to memory. During reset `print_valid`, `halted` and `div_fault` are low and the accumulator is cleared to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; loader window |
| load_we | input | 1 | Loader write enable, honoured only during reset |
| load_addr | input | 4 | Loader target location |
| load_word | input | 14 | Loader word value (0 to 9999) |
| print_valid | output | 1 | One-cycle strobe for a printed word |
| print_word | output | 14 | Printed word value |
| halted | output | 1 | Core has stopped |
| div_fault | output | 1 | Sticky division-by-zero flag |

## Verification
The assertions assume that every word placed in memory, whether by the loader or by a store, is below 10000. They also assume that loader writes arrive only while reset is high. The checks on the print value's range and on the strobe's spacing depend on these two conditions. The bench loads only decimal words below 10000, sets every location before each run, and asserts `load_we` only inside the reset window. The arithmetic therefore always starts from in-range operands.

// File: rtl/dacc_pkg.sv
package dacc_pkg;
  typedef enum logic [2:0] {
    OP_HALT  = 3'd0,
    OP_ADD   = 3'd1,
    OP_MUL   = 3'd2,
    OP_DIV   = 3'd3,
    OP_SUB   = 3'd4,
    OP_LOAD  = 3'd5,
    OP_STORE = 3'd6,
    OP_PRINT = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    S_FETCH,
    S_IR,
    S_OPER,
    S_EXEC,
    S_HALT
  } state_e;
endpackage

// File: rtl/dacc_mem.sv
module dacc_mem #(
  parameter int WORD_W = 14,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  // single write port, registered read: maps onto a block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/dacc_alu.sv
module dacc_alu
  import dacc_pkg::*;
#(
  parameter int WORD_W  = 14,
  parameter int MODULUS = 10000
) (
  input  op_e               op,
  input  logic [WORD_W-1:0] acc,
  input  logic [WORD_W-1:0] opnd,
  output logic [WORD_W-1:0] res,
  output logic              div_zero
);
  localparam logic [WORD_W:0]     MOD_X = (WORD_W+1)'(MODULUS);
  localparam logic [2*WORD_W-1:0] MOD_P = (2*WORD_W)'(MODULUS);

  logic [WORD_W:0]     sum;
  logic [WORD_W:0]     borrow_fix;
  logic [2*WORD_W-1:0] prod;

  always_comb begin
    sum        = {1'b0, acc} + {1'b0, opnd};
    borrow_fix = MOD_X + {1'b0, acc} - {1'b0, opnd};
    prod       = {{WORD_W{1'b0}}, acc} * {{WORD_W{1'b0}}, opnd};
    res        = acc;
    div_zero   = 1'b0;
    case (op)
      OP_ADD:  res = (sum >= MOD_X) ? WORD_W'(sum - MOD_X) : WORD_W'(sum);
      OP_SUB:  res = (acc >= opnd) ? (acc - opnd) : WORD_W'(borrow_fix);
      OP_MUL:  res = WORD_W'(prod % MOD_P);
      OP_DIV: begin
        if (opnd == '0) div_zero = 1'b1;
        else            res = acc / opnd;
      end
      OP_LOAD: res = opnd;
      default: res = acc;
    endcase
  end
endmodule

// File: rtl/dacc_core.sv
module dacc_core
  import dacc_pkg::*;
#(
  parameter int WORD_W   = 14,
  parameter int ADDR_W   = 4,
  parameter int LAST_LOC = 15,
  parameter int RADIX    = 100,
  parameter int MODULUS  = 10000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_we,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [WORD_W-1:0] load_word,
  output logic              print_valid,
  output logic [WORD_W-1:0] print_word,
  output logic              halted,
  output logic              div_fault
);
  localparam int              PC_W     = ADDR_W + 1;
  localparam logic [PC_W-1:0] FIRST_PC = PC_W'(1);
  localparam logic [PC_W-1:0] LAST_PC  = PC_W'(LAST_LOC);
  localparam int              MAX_OP   = 7;

  state_e            state;
  logic [PC_W-1:0]   pc;
  logic [WORD_W-1:0] ir, acc, rdata;
  logic [WORD_W-1:0] opc_w, adr_w;
  op_e               op;
  logic              op_ok, adr_ok;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr, mem_raddr;
  logic [WORD_W-1:0] mem_wdata, alu_res;
  logic              alu_dz;

  // decimal field split of the instruction register
  assign opc_w  = ir / WORD_W'(RADIX);
  assign adr_w  = ir % WORD_W'(RADIX);
  assign op     = op_e'(opc_w[2:0]);
  assign op_ok  = (opc_w != '0) && (opc_w <= WORD_W'(MAX_OP));
  assign adr_ok = (adr_w != '0) && (adr_w <= WORD_W'(LAST_LOC));

  // loader owns the write port during reset, store instruction otherwise
  assign mem_we    = rst ? load_we   : (state == S_EXEC && op == OP_STORE);
  assign mem_waddr = rst ? load_addr : adr_w[ADDR_W-1:0];
  assign mem_wdata = rst ? load_word : acc;
  assign mem_raddr = (state == S_FETCH) ? pc[ADDR_W-1:0] : adr_w[ADDR_W-1:0];

  dacc_mem #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) mem_i (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (mem_raddr),
    .rdata (rdata)
  );

  dacc_alu #(.WORD_W(WORD_W), .MODULUS(MODULUS)) alu_i (
    .op       (op),
    .acc      (acc),
    .opnd     (rdata),
    .res      (alu_res),
    .div_zero (alu_dz)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_FETCH;
      pc          <= FIRST_PC;
      ir          <= '0;
      acc         <= '0;
      print_valid <= 1'b0;
      print_word  <= '0;
      halted      <= 1'b0;
      div_fault   <= 1'b0;
    end else begin
      print_valid <= 1'b0;
      case (state)
        S_FETCH: begin
          if (pc > LAST_PC) begin
            halted <= 1'b1;
            state  <= S_HALT;
          end else begin
            state <= S_IR;
          end
        end
        S_IR: begin
          ir    <= rdata;
          pc    <= pc + PC_W'(1);
          state <= S_OPER;
        end
        S_OPER: begin
          if (!op_ok || !adr_ok) begin
            halted <= 1'b1;
            state  <= S_HALT;
          end else begin
            state <= S_EXEC;
          end
        end
        S_EXEC: begin
          state <= S_FETCH;
          case (op)
            OP_STORE: ;
            OP_PRINT: begin
              print_valid <= 1'b1;
              print_word  <= rdata;
            end
            default: begin
              acc <= alu_res;
              if (alu_dz) div_fault <= 1'b1;
            end
          endcase
        end
        default: state <= S_HALT;
      endcase
    end
  end
endmodule

// File: rtl/dacc_core_chk.sv
module dacc_core_chk #(
  parameter int WORD_W   = 14,
  parameter int PC_W     = 5,
  parameter int LAST_LOC = 15,
  parameter int MODULUS  = 10000
) (
  input logic              clk,
  input logic              rst,
  input logic              print_valid,
  input logic [WORD_W-1:0] print_word,
  input logic              halted,
  input logic              div_fault,
  input logic [PC_W-1:0]   pc
);
  p_reset_clears_r10: assert property (@(posedge clk)
    rst |=> (!print_valid && !halted && !div_fault));

  p_print_in_range_r7: assert property (@(posedge clk) disable iff (rst)
    print_valid |-> (print_word < WORD_W'(MODULUS)));

  p_single_strobe_r7: assert property (@(posedge clk) disable iff (rst)
    print_valid |=> !print_valid);

  p_halt_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  p_silent_after_halt_r9: assert property (@(posedge clk) disable iff (rst)
    halted |=> !print_valid);

  p_fault_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    div_fault |=> div_fault);

  p_pc_window_r8: assert property (@(posedge clk) disable iff (rst)
    (pc != '0) && (pc <= PC_W'(LAST_LOC + 1)));
endmodule

bind dacc_core dacc_core_chk #(
  .WORD_W   (WORD_W),
  .PC_W     (ADDR_W + 1),
  .LAST_LOC (LAST_LOC),
  .MODULUS  (MODULUS)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .print_valid (print_valid),
  .print_word  (print_word),
  .halted      (halted),
  .div_fault   (div_fault),
  .pc          (pc)
);

// File: tb/dacc_core_tb_top.sv
module dacc_core_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_we = 1'b0;
  logic [3:0]  load_addr = '0;
  logic [13:0] load_word = '0;
  logic        print_valid;
  logic [13:0] print_word;
  logic        halted;
  logic        div_fault;

  int n_chk = 0;
  int n_bad = 0;
  int pcnt  = 0;
  int pbuf [8];
  int img  [16];

  always #5 clk = ~clk;

  dacc_core dut_i (
    .clk(clk), .rst(rst), .load_we(load_we), .load_addr(load_addr),
    .load_word(load_word), .print_valid(print_valid), .print_word(print_word),
    .halted(halted), .div_fault(div_fault)
  );

  // capture print strobes away from the active edge
  always @(negedge clk) begin
    if (!rst && print_valid && pcnt < 8) begin
      pbuf[pcnt] = int'(print_word);
      pcnt++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_img();
    for (int i = 0; i < 16; i++) img[i] = 0;
  endtask

  task automatic run_prog();
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      load_we   = 1'b1;
      load_addr = 4'(i);
      load_word = 14'(img[i]);
    end
    @(negedge clk);
    load_we = 1'b0;
    pcnt    = 0;
    rst     = 1'b0;
    for (int c = 0; c < 400 && !halted; c++) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  // {opcode, acc operand, memory operand, expected print, expected fault}
  localparam int VEC [10][5] = '{
    '{1, 4444,  112, 4556, 0},   // R2 plain add
    '{1, 9999,    1,    0, 0},   // R2 wrap at 10000
    '{4,    5,    7, 9998, 0},   // R3 borrow wraps
    '{4,  100,    1,   99, 0},   // R3 plain subtract
    '{2,  123,  100, 2300, 0},   // R4 product modulo
    '{2, 9999, 9999,    1, 0},   // R4 largest product
    '{3, 4556,    2, 2278, 0},   // R5 exact divide
    '{3,    7,    3,    2, 0},   // R5 truncation
    '{3,    5,    0,    5, 1},   // R5 zero divisor
    '{2,   99,   99, 9801, 0}    // R4 product in range
  };

  initial begin
    repeat (4) @(negedge clk);
    // R10 reset state
    check("R10 print_valid in reset", int'(print_valid), 0);
    check("R10 halted in reset", int'(halted), 0);
    check("R10 div_fault in reset", int'(div_fault), 0);

    // arithmetic vectors: load 10, op 11, store 12, print 12, halt
    for (int v = 0; v < 10; v++) begin
      clear_img();
      img[1] = 510; img[2] = VEC[v][0] * 100 + 11; img[3] = 612;
      img[4] = 712; img[5] = 0;
      img[10] = VEC[v][1]; img[11] = VEC[v][2]; img[12] = 1234;
      run_prog();
      check($sformatf("R2 R3 R4 R5 R6 vector %0d print count", v), pcnt, 1);
      check($sformatf("R2 R3 R4 R5 R6 vector %0d result", v), pbuf[0], VEC[v][3]);
      check($sformatf("R5 vector %0d fault flag", v), int'(div_fault), VEC[v][4]);
      check($sformatf("R9 vector %0d halted", v), int'(halted), 1);
    end

    // R1 R6 R7 worked program: (4444+112)/2, then the stored sum
    clear_img();
    img[1] = 511; img[2] = 112; img[3] = 613; img[4] = 513;
    img[5] = 314; img[6] = 615; img[7] = 715; img[8] = 713; img[9] = 0;
    img[11] = 4444; img[12] = 112; img[13] = 7777; img[14] = 2;
    run_prog();
    check("R7 worked program print count", pcnt, 2);
    check("R1 worked program quotient", pbuf[0], 2278);
    check("R6 store overwrote location 13", pbuf[1], 4556);

    // R8 start at location 1: location 0 holds a print that must not run
    clear_img();
    img[0] = 710; img[1] = 0; img[10] = 55;
    run_prog();
    check("R8 location 0 not executed", pcnt, 0);
    check("R8 halted at location 1", int'(halted), 1);

    // R9 undefined opcode 08 halts before the following print
    clear_img();
    img[1] = 810; img[2] = 710; img[10] = 42;
    run_prog();
    check("R9 undefined opcode no print", pcnt, 0);
    check("R9 undefined opcode halted", int'(halted), 1);

    // R1 operand location 20 is out of range and halts
    clear_img();
    img[1] = 720; img[2] = 710; img[10] = 42;
    run_prog();
    check("R1 out-of-range operand no print", pcnt, 0);
    check("R1 out-of-range operand halted", int'(halted), 1);

    // R9 running past location 15 halts
    clear_img();
    for (int i = 1; i < 16; i++) img[i] = 501;
    run_prog();
    check("R9 pc past end halted", int'(halted), 1);
    check("R9 pc past end no print", pcnt, 0);

    // R5 R10 fault is sticky, accumulator starts at 0
    clear_img();
    img[1] = 310; img[2] = 111; img[3] = 612; img[4] = 712; img[5] = 0;
    img[10] = 0; img[11] = 5;
    run_prog();
    check("R10 accumulator cleared, R5 unchanged after fault", pbuf[0], 5);
    check("R5 fault stays set", int'(div_fault), 1);

    // R10 a new reset clears the fault
    clear_img();
    img[1] = 710; img[2] = 0; img[10] = 9999;
    run_prog();
    check("R10 fault cleared by reset", int'(div_fault), 0);
    check("R7 print of 9999", pbuf[0], 9999);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule